// File: doc/BRIEF.md
# Multicycle Issue Hazard Checker

This block sits at the issue point of an in-order pipeline whose execute stage holds several functional units with unequal latencies: a one-cycle integer unit, a three-cycle floating-point adder, a six-cycle multiplier and a 24-cycle divider. The adder and the multiplier are fully pipelined. The divider is not. Each cycle the block receives at most one decoded instruction, given as a unit code, a destination register and a write enable. It decides at once whether that instruction may issue or must stall.

Three hazards can stop issue. The first is a clash on the single register-file write port: a shift register records which future cycles already hold a write. The second is a divider that is still working on an earlier divide. The third is a write-after-write hazard: a pending-write bit vector marks destinations that are still in flight. Write-after-read needs no check, because operands are read at issue.

Along with the decision, the block reports the write-back delay of the presented instruction. It also drives the scheduled write-back of the current cycle (valid and register number), so the pipeline can steer the write port from it.

Top module: `mc_issue_ctrl`

## Requirements
- R1: After reset no write-back is scheduled (`wb_valid` low), no register is pending and the divider is free, so the first instruction presented issues whatever its unit.
- R2: Unit codes and latencies are: 0 = integer, 1 cycle; 1 = FP add, 3 cycles; 2 = multiply, 6 cycles; 3 = divide, 24 cycles. `wb_lat` shows the latency of the presented unit in the same cycle.
- R3: While `in_valid` is high, exactly one of `issue` and `stall` is high in that same cycle.
- R4: An instruction with write enable that issues in cycle t with latency L raises `wb_valid` with `wb_rd` equal to its destination in cycle t+L, exactly once.
- R5: An instruction with write enable stalls if a write-back is already reserved for cycle t+L.
- R6: An instruction with write enable stalls if its destination matches an issued instruction whose write-back lies after the current cycle. A write-back that happens in the current cycle does not block.
- R7: A divide stalls while an earlier divide issued in cycle d is still running (cycles d+1 to d+23), whether or not either divide has write enable. A divide may issue from cycle d+24 on. Other units are not blocked by a running divide.
- R8: An instruction with write enable low reserves no write slot, is not checked for write-after-write, and produces no write-back.
- R9: A stalled instruction changes no state: it gets no write slot, marks no register pending and does not start the divider.
- R10: With `in_valid` low, `issue` and `stall` stay low and no state changes.
- R11: The integer unit, the adder and the multiplier accept one instruction per cycle when their destinations differ and their write-back cycles do not collide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is presented this cycle |
| in_unit | input | 2 | Functional-unit code (see R2) |
| in_rd | input | 5 | Destination register number |
| in_we | input | 1 | Instruction writes its destination register |
| issue | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction must be held this cycle |
| wb_lat | output | 5 | Cycles from issue to write-back for the presented unit |
| wb_valid | output | 1 | A scheduled write-back occurs this cycle |
| wb_rd | output | 5 | Register written by that write-back |

## Verification
A corrupted slot in the reservation shift register shows up at the ports in one of two ways. It can give a missing, extra or misnumbered write-back exactly in the cycle the slot reaches the front. It can also give a wrong `issue`/`stall` the first time a later instruction probes that slot, which may be up to 24 cycles after the fault. A stuck pending bit or a wrong divider count shows up as an unexpected stall, or a missing one, on the next instruction to the same register or on the next divide. The bench therefore compares every cycle's write-back against a model timeline. It drives back-to-back and spaced sequences that land on the exact boundary cycles (write-back in the current cycle, divider release at 24 cycles).

// File: rtl/mc_issue_pkg.sv
package mc_issue_pkg;

  typedef enum logic [1:0] {
    UNIT_INT  = 2'd0,
    UNIT_FADD = 2'd1,
    UNIT_MUL  = 2'd2,
    UNIT_DIV  = 2'd3
  } unit_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/mc_wport_sched.sv
module mc_wport_sched #(
  parameter int SLOTS = 24,
  parameter int REG_W = 5,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] chk_idx,
  input  logic             alloc_en,
  input  logic [REG_W-1:0] alloc_rd,
  output logic             chk_busy,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_rd
);

  // Slot k holds the write-back happening k cycles from now (slot 0 = this cycle).
  logic [SLOTS-1:0] slot_v;
  logic [REG_W-1:0] slot_rd [SLOTS];

  generate
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
      logic             v_q;
      logic [REG_W-1:0] rd_q;
      logic             nxt_v;
      logic [REG_W-1:0] nxt_rd;

      if (j == SLOTS - 1) begin : g_last
        assign nxt_v  = 1'b0;
        assign nxt_rd = '0;
      end else begin : g_mid
        assign nxt_v  = slot_v[j+1];
        assign nxt_rd = slot_rd[j+1];
      end

      // An instruction needing slot chk_idx now lands one position lower after the shift.
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q  <= 1'b0;
          rd_q <= '0;
        end else if (alloc_en && (chk_idx == IDX_W'(j + 1))) begin
          v_q  <= 1'b1;
          rd_q <= alloc_rd;
        end else begin
          v_q  <= nxt_v;
          rd_q <= nxt_rd;
        end
      end

      assign slot_v[j]  = v_q;
      assign slot_rd[j] = rd_q;
    end
  endgenerate

  always_comb begin
    chk_busy = 1'b0;
    if (chk_idx < IDX_W'(SLOTS)) chk_busy = slot_v[chk_idx];
  end

  assign wb_valid = slot_v[0];
  assign wb_rd    = slot_rd[0];

  // R5: the top never books a slot that is already held
  p_port_single_r5: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> !chk_busy);

  // R4: a one-cycle booking appears at the write port in the next cycle
  p_wb_next_r4: assert property (@(posedge clk) disable iff (rst)
    (alloc_en && chk_idx == IDX_W'(1)) |=> (wb_valid && wb_rd == $past(alloc_rd)));

endmodule

// File: rtl/mc_div_track.sv
module mc_div_track #(
  parameter int LAT_DIV = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(LAT_DIV + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(LAT_DIV - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

  // R7: a divide never starts on top of a running one
  p_div_serial_r7: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R7: after a start the unit reports busy in the next cycle
  p_div_hold_r7: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

endmodule

// File: rtl/mc_waw_table.sv
module mc_waw_table #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] chk_rd,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_rd,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_rd,
  output logic             chk_pend
);

  localparam int NREG = 1 << REG_W;

  logic [NREG-1:0] pend_q;
  logic [NREG-1:0] pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_en) pend_d[clr_rd] = 1'b0;
    if (set_en) pend_d[set_rd] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  // A write leaving the port this cycle no longer counts as in flight.
  assign chk_pend = pend_q[chk_rd] && !(clr_en && (clr_rd == chk_rd));

  // R6: every write-back belongs to a register marked pending
  p_wb_was_pending_r6: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> pend_q[clr_rd]);

  // R6: an issued write marks its destination in the next cycle
  p_set_marks_r6: assert property (@(posedge clk) disable iff (rst)
    set_en |=> pend_q[$past(set_rd)]);

endmodule

// File: rtl/mc_issue_ctrl.sv
module mc_issue_ctrl #(
  parameter int REG_W    = 5,
  parameter int LAT_INT  = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_MUL  = 6,
  parameter int LAT_DIV  = 24
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  input  logic [1:0]                          in_unit,
  input  logic [REG_W-1:0]                    in_rd,
  input  logic                                in_we,
  output logic                                issue,
  output logic                                stall,
  output logic [$clog2(LAT_DIV+1)-1:0]        wb_lat,
  output logic                                wb_valid,
  output logic [REG_W-1:0]                    wb_rd
);
  import mc_issue_pkg::*;

  localparam int MAX_LAT = max_of4(LAT_INT, LAT_FADD, LAT_MUL, LAT_DIV);
  localparam int LAT_W   = $clog2(LAT_DIV + 1);
  localparam int SLOTS   = MAX_LAT;

  unit_e            unit;
  logic [LAT_W-1:0] lat;
  logic             port_busy;
  logic             div_busy;
  logic             rd_pend;
  logic             hz_port;
  logic             hz_div;
  logic             hz_waw;
  logic             blocked;
  logic             alloc_en;
  logic             div_start;

  assign unit = unit_e'(in_unit);

  always_comb begin
    case (unit)
      UNIT_INT:  lat = LAT_W'(LAT_INT);
      UNIT_FADD: lat = LAT_W'(LAT_FADD);
      UNIT_MUL:  lat = LAT_W'(LAT_MUL);
      default:   lat = LAT_W'(LAT_DIV);
    endcase
  end

  assign hz_port = in_we && port_busy;
  assign hz_div  = (unit == UNIT_DIV) && div_busy;
  assign hz_waw  = in_we && rd_pend;
  assign blocked = hz_port || hz_div || hz_waw;

  assign issue     = in_valid && !blocked;
  assign stall     = in_valid && blocked;
  assign wb_lat    = lat;
  assign alloc_en  = issue && in_we;
  assign div_start = issue && (unit == UNIT_DIV);

  mc_wport_sched #(
    .SLOTS (SLOTS),
    .REG_W (REG_W),
    .IDX_W (LAT_W)
  ) u_wport (
    .clk      (clk),
    .rst      (rst),
    .chk_idx  (lat),
    .alloc_en (alloc_en),
    .alloc_rd (in_rd),
    .chk_busy (port_busy),
    .wb_valid (wb_valid),
    .wb_rd    (wb_rd)
  );

  mc_div_track #(
    .LAT_DIV (LAT_DIV)
  ) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .busy  (div_busy)
  );

  mc_waw_table #(
    .REG_W (REG_W)
  ) u_waw (
    .clk      (clk),
    .rst      (rst),
    .chk_rd   (in_rd),
    .set_en   (alloc_en),
    .set_rd   (in_rd),
    .clr_en   (wb_valid),
    .clr_rd   (wb_rd),
    .chk_pend (rd_pend)
  );

  // R3: a presented instruction either issues or stalls, never both
  p_issue_xor_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (issue != stall));

  // R10: nothing presented, nothing decided
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (!issue && !stall));

endmodule

// File: tb/mc_issue_ctrl_tb_top.sv
module mc_issue_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_unit = 2'd0;
  logic [4:0] in_rd = 5'd0;
  logic       in_we = 1'b0;
  logic       issue;
  logic       stall;
  logic [4:0] wb_lat;
  logic       wb_valid;
  logic [4:0] wb_rd;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  // model state
  int exp_wb [int];
  int pend_wb [32];
  int div_free = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  mc_issue_ctrl dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_unit  (in_unit),
    .in_rd    (in_rd),
    .in_we    (in_we),
    .issue    (issue),
    .stall    (stall),
    .wb_lat   (wb_lat),
    .wb_valid (wb_valid),
    .wb_rd    (wb_rd)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  function automatic int lat_of(input logic [1:0] u);
    case (u)
      2'd0:    return 1;
      2'd1:    return 3;
      2'd2:    return 6;
      default: return 24;
    endcase
  endfunction

  // monitor: compares the write port against the expected timeline (R4, R8, R9)
  always @(negedge clk) begin
    if (mon_en) begin
      if (exp_wb.exists(cyc)) begin
        chk(wb_valid == 1'b1, "R4", "wb_valid", int'(wb_valid), 1);
        chk(wb_rd == 5'(exp_wb[cyc]), "R4", "wb_rd", int'(wb_rd), exp_wb[cyc]);
        exp_wb.delete(cyc);
      end else begin
        chk(wb_valid == 1'b0, "R9", "unexpected wb_valid", int'(wb_valid), 0);
      end
    end
  end

  // driver: presents one instruction (or nothing) for one cycle and checks the decision
  task automatic present(input bit v, input logic [1:0] u, input logic [4:0] rd,
                         input bit we, input string tag);
    int  c;
    int  l;
    bit  blk;
    bit  e_issue;
    bit  e_stall;
    @(negedge clk);
    in_valid = v;
    in_unit  = u;
    in_rd    = rd;
    in_we    = we;
    #1;
    c   = cyc;
    l   = lat_of(u);
    blk = 1'b0;
    if (u == 2'd3 && c < div_free) blk = 1'b1;
    if (we && exp_wb.exists(c + l)) blk = 1'b1;
    if (we && pend_wb[rd] > c) blk = 1'b1;
    e_issue = v && !blk;
    e_stall = v && blk;
    chk(issue == e_issue, tag, "issue", int'(issue), int'(e_issue));
    chk(stall == e_stall, tag, "stall", int'(stall), int'(e_stall));
    if (v) chk(int'(wb_lat) == l, "R2", "wb_lat", int'(wb_lat), l);
    if (e_issue) begin
      if (we) begin
        exp_wb[c + l] = int'(rd);
        pend_wb[rd]   = c + l;
      end
      if (u == 2'd3) div_free = c + 24;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) present(1'b0, 2'd0, 5'd0, 1'b0, "R10");
  endtask

  initial begin
    int d0;
    int c0;
    for (int i = 0; i < 32; i++) pend_wb[i] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mon_en = 1'b1;
    #1;
    // R1: reset state
    chk(wb_valid == 1'b0, "R1", "wb_valid after reset", int'(wb_valid), 0);
    chk(issue == 1'b0 && stall == 1'b0, "R1", "idle decision after reset", int'(issue | stall), 0);
    present(1'b1, 2'd3, 5'd1, 1'b1, "R1");           // first divide issues
    idle(2);

    // R11: pipelined units back to back, R2 latencies
    present(1'b1, 2'd0, 5'd2, 1'b1, "R11");
    present(1'b1, 2'd1, 5'd3, 1'b1, "R11");
    present(1'b1, 2'd2, 5'd4, 1'b1, "R11");
    present(1'b1, 2'd0, 5'd5, 1'b1, "R11");
    idle(8);

    // R5: multiply then FP add landing on the same write cycle
    present(1'b1, 2'd2, 5'd6, 1'b1, "R5");          // wb at c+6
    idle(2);
    present(1'b1, 2'd1, 5'd7, 1'b1, "R5");          // wb at c+6 -> stall
    present(1'b1, 2'd1, 5'd7, 1'b1, "R5");          // wb at c+7 -> issue
    idle(8);

    // R6: write-after-write, and release when the earlier write leaves
    present(1'b1, 2'd1, 5'd9, 1'b1, "R6");          // fadd r9, wb c+3
    present(1'b1, 2'd0, 5'd9, 1'b1, "R6");          // WAW stall
    present(1'b1, 2'd0, 5'd9, 1'b1, "R6");          // still blocked
    present(1'b1, 2'd0, 5'd9, 1'b1, "R6");          // earlier write now: issues
    idle(4);

    // R8: no-write instruction ignores port and WAW
    c0 = cyc + 1;
    present(1'b1, 2'd2, 5'd10, 1'b1, "R8");
    idle(1);
    present(1'b1, 2'd1, 5'd11, 1'b1, "R8");         // wb at c0+5
    idle(1);
    present(1'b1, 2'd0, 5'd11, 1'b0, "R8");         // slot c0+5 held, r11 pending: still issues
    chk(c0 + 4 == cyc, "R8", "sequence alignment", cyc, c0 + 4);
    idle(8);

    // R7: divider busy window
    d0 = cyc + 1;
    present(1'b1, 2'd3, 5'd12, 1'b1, "R7");
    idle(1);
    present(1'b1, 2'd3, 5'd13, 1'b1, "R7");         // busy -> stall
    present(1'b1, 2'd0, 5'd14, 1'b1, "R7");         // integer not blocked
    while (cyc + 1 < d0 + 23) idle(1);
    present(1'b1, 2'd3, 5'd13, 1'b0, "R7");         // d0+23 still busy
    present(1'b1, 2'd3, 5'd13, 1'b1, "R7");         // d0+24 released
    idle(30);

    // mixed random stream, R3/R5/R6/R7/R9 against the model
    for (int i = 0; i < 600; i++) begin
      logic [1:0] u;
      logic [4:0] r;
      bit         w;
      bit         v;
      u = 2'($urandom_range(0, 3));
      if (u == 2'd3 && $urandom_range(0, 3) != 0) u = 2'd0;
      r = 5'($urandom_range(0, 7));
      w = ($urandom_range(0, 7) != 0);
      v = ($urandom_range(0, 5) != 0);
      present(v, u, r, w, "R3");
    end
    idle(30);
    chk(exp_wb.size() == 0, "R4", "write-backs left over", exp_wb.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule